// File: doc/BRIEF.md
# Descriptor Cache Flush Controller

This block runs flush commands, one at a time, against a small direct-mapped cache of descriptor lines. It also manages a table of address-blocking slots. A command arrives on a valid/ready port. It carries a 40-bit descriptor address, a 16-bit command number, a status-request bit, a command kind, a slot index and a set of flush control bits. A flush can do several things, in this order: free a blocking slot, forward the entries held for the addressed queue, write the line back, optionally keep the line valid, flush a companion line, and claim the slot for the address. A whole-cache flush writes back and invalidates every valid line. It then locks the cache until a whole-cache unblock command arrives.

Clients fill lines through a fill port, and those fills are refused for blocked addresses. A lookup port reports whether an address is blocked. The memory write-back is modelled as a request/acknowledge handshake. Forwarding is modelled as one pulse per held entry. Completion is reported by a status record that gives pass or error, and a hit flag for the primary line.

Top module: `dcf_flush_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1, `st_valid`, `wb_req` and `fwd_pulse` are 0, and every lookup reports not blocked.
- R2: A command produces exactly one one-cycle `st_valid` pulse carrying its `cmd_num`, and only when `cmd_stat_req` was 1. With `cmd_stat_req` at 0, no pulse appears.
- R3: A flush (kind 0) whose address hits a valid line issues one write-back handshake with that address, then invalidates the line. The line index is the address modulo `NUM_LINES`, and a hit needs the full stored address to match. A miss completes with pass, `st_hit`=0 and no write-back.
- R4: With `cmd_keep_line` set, a hitting line is written back but stays valid, so a repeat flush hits again.
- R5: With `cmd_fwd_all` set and a hit, `fwd_pulse` is raised once per held entry before the write-back, and the held count of that line becomes 0.
- R6: With `cmd_ext` set, the companion line at address + `COMP_OFS` is flushed after the primary line, using the same rules.
- R7: With `cmd_release` set, slot `cmd_slot` is freed before execution. If that slot was already free, the command reports an error and nothing else happens.
- R8: With `cmd_block` set, a slot still occupied after the release step gives an error and no flush. On success, the slot holds the address: lookups of it report blocked, and fills to it are refused.
- R9: A flush with `cmd_whole` set ignores all other fields. It writes back and invalidates every valid line in index order and leaves slots unchanged. While the cache stays locked, lookups report blocked, fills are refused, and other flushes report an error.
- R10: Kind 1 frees slot `cmd_slot` (error if it was free). Kind 2 clears the whole-cache lock with pass. Kind 3 reports an error and changes nothing.
- R11: `lk_blocked` gives the blocked state of `lk_addr` one cycle after it is presented. `fill_done` answers a one-cycle `fill_valid` in the next cycle, with `fill_ok` set when the line was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command taken when valid |
| cmd_num | input | 16 | Command number echoed in status |
| cmd_stat_req | input | 1 | Status record wanted |
| cmd_kind | input | 2 | 0 flush, 1 free slot, 2 unlock cache, 3 reserved |
| cmd_addr | input | 40 | Descriptor address |
| cmd_slot | input | 2 | Blocking slot index |
| cmd_fwd_all | input | 1 | Forward held entries first |
| cmd_release | input | 1 | Free the slot before execution |
| cmd_keep_line | input | 1 | Write back without invalidating |
| cmd_block | input | 1 | Claim the slot for the address |
| cmd_whole | input | 1 | Flush and lock the whole cache |
| cmd_ext | input | 1 | Also flush the companion line |
| fill_valid | input | 1 | Fill request (one cycle) |
| fill_addr | input | 40 | Fill address |
| fill_cnt | input | 4 | Held-entry count for the filled line |
| fill_done | output | 1 | Fill answered |
| fill_ok | output | 1 | Fill written |
| lk_addr | input | 40 | Lookup address |
| lk_blocked | output | 1 | Lookup address is blocked |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 40 | Write-back line address |
| wb_ack | input | 1 | Write-back acknowledge |
| fwd_pulse | output | 1 | One forwarded entry |
| st_valid | output | 1 | Status record valid |
| st_num | output | 16 | Command number of the status |
| st_err | output | 1 | Command failed |
| st_hit | output | 1 | Primary line hit |

## Verification
Directed sequences try flushes on hit and miss lines. They tell the invalidating flush apart from the keeping one by repeating the flush, and they separate forwarding counts of zero and non-zero. Slot cases cover release of a free slot, a claim on an occupied slot, and release followed by claim. Each is told apart by error status, by write-back count and by later lookups and fills. A whole-cache flush issued with junk in all other fields must write back exactly the valid lines in index order, and must leave a previously claimed slot in place. Seeded random mixes of fills, lookups and all four command kinds over a small address pool force index conflicts, compared against a bench model of lines, slots and the lock.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic [1:0] {
    KIND_FLUSH     = 2'd0,
    KIND_FREE_SLOT = 2'd1,
    KIND_FREE_ALL  = 2'd2,
    KIND_RSVD      = 2'd3
  } dcf_kind_e;

  typedef struct packed {
    logic fwd;
    logic rel;
    logic keep;
    logic blk;
    logic whole;
    logic ext;
  } dcf_flags_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_LOOK, ST_FWD, ST_WB, ST_NEXT, ST_ALL, ST_DONE
  } dcf_state_e;
endpackage

// File: rtl/dcf_slot_table.sv
module dcf_slot_table #(
  parameter int NSLOT  = 4,
  parameter int ADDR_W = 40,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rel_en,
  input  logic              clm_en,
  input  logic [SW-1:0]     sel,
  input  logic [ADDR_W-1:0] clm_addr,
  output logic [NSLOT-1:0]  occ_o,
  input  logic [ADDR_W-1:0] qa_addr,
  output logic              qa_hit,
  input  logic [ADDR_W-1:0] qb_addr,
  output logic              qb_hit
);
  logic [NSLOT-1:0]  occ_q;
  logic [ADDR_W-1:0] addr_q [NSLOT];
  logic [NSLOT-1:0]  eq_a, eq_b;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        occ_q[i]  <= 1'b0;
        addr_q[i] <= '0;
      end else if (clm_en && sel == SW'(i)) begin
        occ_q[i]  <= 1'b1;
        addr_q[i] <= clm_addr;
      end else if (rel_en && sel == SW'(i)) begin
        occ_q[i]  <= 1'b0;
      end
    end
    assign eq_a[i] = occ_q[i] && (addr_q[i] == qa_addr);
    assign eq_b[i] = occ_q[i] && (addr_q[i] == qb_addr);
  end

  assign occ_o  = occ_q;
  assign qa_hit = |eq_a;
  assign qb_hit = |eq_b;

  // R7: the sequencer only frees a slot that is taken
  assert_release_taken_R7: assert property (@(posedge clk) disable iff (rst)
    rel_en |-> occ_q[sel]);
  // R8: a claim only lands on a free slot
  assert_claim_free_R8: assert property (@(posedge clk) disable iff (rst)
    clm_en |-> !occ_q[sel]);
  // R8: a successful claim leaves the slot occupied
  assert_claim_sticks_R8: assert property (@(posedge clk) disable iff (rst)
    clm_en |=> occ_q[$past(sel)]);
endmodule

// File: rtl/dcf_line_store.sv
module dcf_line_store #(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 40,
  parameter int QW        = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic              w_valid,
  input  logic [ADDR_W-1:0] w_tag,
  input  logic [QW-1:0]     w_qcnt,
  input  logic [IDX_W-1:0]  r_idx,
  output logic              r_valid,
  output logic [ADDR_W-1:0] r_tag,
  output logic [QW-1:0]     r_qcnt
);
  logic [NUM_LINES-1:0] valid_q;
  logic [ADDR_W-1:0]    tag_mem  [NUM_LINES];
  logic [QW-1:0]        qcnt_mem [NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (we) valid_q[w_idx] <= w_valid;
  end

  // tag and count arrays carry no reset so they map onto distributed RAM
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx]  <= w_tag;
      qcnt_mem[w_idx] <= w_qcnt;
    end
  end

  assign r_valid = valid_q[r_idx];
  assign r_tag   = tag_mem[r_idx];
  assign r_qcnt  = qcnt_mem[r_idx];
endmodule

// File: rtl/dcf_seq.sv
module dcf_seq import dcf_pkg::*; #(
  parameter int ADDR_W    = 40,
  parameter int NUM_W     = 16,
  parameter int NSLOT     = 4,
  parameter int NUM_LINES = 8,
  parameter int QW        = 4,
  parameter int COMP_OFS  = 4,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [NUM_W-1:0]  cmd_num,
  input  logic              cmd_stat_req,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SW-1:0]     cmd_slot,
  input  dcf_flags_t        cmd_flags,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [QW-1:0]     fill_cnt,
  input  logic              fill_slot_hit,
  output logic              fill_done,
  output logic              fill_ok,
  input  logic [NSLOT-1:0]  slot_occ,
  output logic              slot_rel,
  output logic              slot_clm,
  output logic [SW-1:0]     slot_sel,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_widx,
  output logic              st_wvalid,
  output logic [ADDR_W-1:0] st_wtag,
  output logic [QW-1:0]     st_wqcnt,
  output logic [IDX_W-1:0]  st_ridx,
  input  logic              st_rvalid,
  input  logic [ADDR_W-1:0] st_rtag,
  input  logic [QW-1:0]     st_rqcnt,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack,
  output logic              fwd_pulse,
  output logic              st_valid,
  output logic [NUM_W-1:0]  st_num,
  output logic              st_err,
  output logic              st_hit,
  output logic              locked
);
  localparam logic [IDX_W:0] ALL_END = (IDX_W+1)'(NUM_LINES);

  dcf_state_e        state;
  logic [NUM_W-1:0]  c_num;
  logic              c_stat;
  dcf_kind_e         c_kind;
  logic [ADDR_W-1:0] c_addr, tgt;
  logic [SW-1:0]     c_slot;
  dcf_flags_t        c_fl;
  logic              second, err_q, hit_q, lock_q, wb_req_q, fwd_q;
  logic [IDX_W:0]    all_idx;
  logic [QW-1:0]     fwd_left;
  logic              st_valid_q, st_err_q, st_hit_q, fill_done_q, fill_ok_q;
  logic [NUM_W-1:0]  st_num_q;
  logic              line_hit, fill_take, last_line, wb_done;

  assign cmd_ready = (state == ST_IDLE);
  assign st_ridx   = (state == ST_ALL) ? all_idx[IDX_W-1:0] : tgt[IDX_W-1:0];
  assign line_hit  = st_rvalid && (st_rtag == tgt);
  assign fill_take = (state == ST_IDLE) && !cmd_valid && fill_valid &&
                     !lock_q && !fill_slot_hit;
  assign last_line = !(c_fl.ext && !second);
  assign wb_done   = wb_req_q && wb_ack;

  // slot table control
  always_comb begin
    slot_sel  = c_slot;
    slot_addr = c_addr;
    slot_rel  = 1'b0;
    slot_clm  = 1'b0;
    if (state == ST_DECIDE) begin
      if (c_kind == KIND_FREE_SLOT && slot_occ[c_slot]) slot_rel = 1'b1;
      if (c_kind == KIND_FLUSH && !c_fl.whole && !lock_q && c_fl.rel &&
          slot_occ[c_slot]) slot_rel = 1'b1;
    end
    if (state == ST_NEXT && last_line && c_fl.blk) slot_clm = 1'b1;
  end

  // line store write port
  always_comb begin
    st_we     = 1'b0;
    st_widx   = tgt[IDX_W-1:0];
    st_wvalid = 1'b1;
    st_wtag   = tgt;
    st_wqcnt  = '0;
    if (fill_take) begin
      st_we    = 1'b1;
      st_widx  = fill_addr[IDX_W-1:0];
      st_wtag  = fill_addr;
      st_wqcnt = fill_cnt;
    end else if (state == ST_FWD && fwd_left == QW'(1)) begin
      st_we = 1'b1;
    end else if (state == ST_WB && wb_done && (c_fl.whole || !c_fl.keep)) begin
      st_we     = 1'b1;
      st_wvalid = 1'b0;
      st_wqcnt  = st_rqcnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      c_num       <= '0;
      c_stat      <= 1'b0;
      c_kind      <= KIND_FLUSH;
      c_addr      <= '0;
      c_slot      <= '0;
      c_fl        <= '0;
      tgt         <= '0;
      second      <= 1'b0;
      err_q       <= 1'b0;
      hit_q       <= 1'b0;
      lock_q      <= 1'b0;
      wb_req_q    <= 1'b0;
      fwd_q       <= 1'b0;
      all_idx     <= '0;
      fwd_left    <= '0;
      st_valid_q  <= 1'b0;
      st_num_q    <= '0;
      st_err_q    <= 1'b0;
      st_hit_q    <= 1'b0;
      fill_done_q <= 1'b0;
      fill_ok_q   <= 1'b0;
    end else begin
      st_valid_q  <= 1'b0;
      fwd_q       <= 1'b0;
      fill_done_q <= fill_valid;
      fill_ok_q   <= fill_take;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          c_num   <= cmd_num;
          c_stat  <= cmd_stat_req;
          c_kind  <= dcf_kind_e'(cmd_kind);
          c_addr  <= cmd_addr;
          c_slot  <= cmd_slot;
          c_fl    <= cmd_flags;
          second  <= 1'b0;
          err_q   <= 1'b0;
          hit_q   <= 1'b0;
          all_idx <= '0;
          state   <= ST_DECIDE;
        end
        ST_DECIDE: begin
          state <= ST_DONE;
          case (c_kind)
            KIND_FLUSH: begin
              if (c_fl.whole) state <= ST_ALL;
              else if (lock_q || (c_fl.rel && !slot_occ[c_slot]) ||
                       (c_fl.blk && !c_fl.rel && slot_occ[c_slot])) err_q <= 1'b1;
              else begin
                tgt   <= c_addr;
                state <= ST_LOOK;
              end
            end
            KIND_FREE_SLOT: err_q <= !slot_occ[c_slot];
            KIND_FREE_ALL:  lock_q <= 1'b0;
            default:        err_q <= 1'b1;
          endcase
        end
        ST_LOOK: begin
          if (!second) hit_q <= line_hit;
          if (line_hit && c_fl.fwd && !second && st_rqcnt != '0) begin
            fwd_left <= st_rqcnt;
            state    <= ST_FWD;
          end else if (line_hit) state <= ST_WB;
          else state <= ST_NEXT;
        end
        ST_FWD: begin
          fwd_q    <= 1'b1;
          fwd_left <= fwd_left - QW'(1);
          if (fwd_left == QW'(1)) state <= ST_WB;
        end
        ST_WB: begin
          if (!wb_req_q) wb_req_q <= 1'b1;
          else if (wb_ack) begin
            wb_req_q <= 1'b0;
            if (c_fl.whole) begin
              all_idx <= all_idx + 1'b1;
              state   <= ST_ALL;
            end else state <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (!last_line) begin
            second <= 1'b1;
            tgt    <= c_addr + ADDR_W'(COMP_OFS);
            state  <= ST_LOOK;
          end else state <= ST_DONE;
        end
        ST_ALL: begin
          if (all_idx == ALL_END) begin
            lock_q <= 1'b1;
            state  <= ST_DONE;
          end else if (st_rvalid) begin
            tgt   <= st_rtag;
            state <= ST_WB;
          end else all_idx <= all_idx + 1'b1;
        end
        ST_DONE: begin
          st_valid_q <= c_stat;
          st_num_q   <= c_num;
          st_err_q   <= err_q;
          st_hit_q   <= hit_q;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wb_req    = wb_req_q;
  assign wb_addr   = tgt;
  assign fwd_pulse = fwd_q;
  assign st_valid  = st_valid_q;
  assign st_num    = st_num_q;
  assign st_err    = st_err_q;
  assign st_hit    = st_hit_q;
  assign fill_done = fill_done_q;
  assign fill_ok   = fill_ok_q;
  assign locked    = lock_q;

  // R3: a write-back request holds with a steady address until acknowledged
  assert_wb_hold_R3: assert property (@(posedge clk) disable iff (rst)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr));
  // R2: status is a single-cycle pulse
  assert_st_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> !st_valid);
  // R2: a taken command makes the controller busy
  assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_ready);
  // R5: forwarding never overlaps a write-back
  assert_fwd_first_R5: assert property (@(posedge clk) disable iff (rst)
    fwd_pulse |-> !wb_req);
  // R9: a locked cache rejects an ordinary flush
  assert_locked_err_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECIDE && lock_q && c_kind == KIND_FLUSH && !c_fl.whole) |=> err_q);
  // R11: no fill is written while the cache is locked
  assert_fill_lock_R11: assert property (@(posedge clk) disable iff (rst)
    locked |=> !fill_ok);
endmodule

// File: rtl/dcf_flush_ctrl.sv
module dcf_flush_ctrl import dcf_pkg::*; #(
  parameter int ADDR_W    = 40,
  parameter int NUM_W     = 16,
  parameter int NSLOT     = 4,
  parameter int NUM_LINES = 8,
  parameter int QW        = 4,
  parameter int COMP_OFS  = 4,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [NUM_W-1:0]  cmd_num,
  input  logic              cmd_stat_req,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SW-1:0]     cmd_slot,
  input  logic              cmd_fwd_all,
  input  logic              cmd_release,
  input  logic              cmd_keep_line,
  input  logic              cmd_block,
  input  logic              cmd_whole,
  input  logic              cmd_ext,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [QW-1:0]     fill_cnt,
  output logic              fill_done,
  output logic              fill_ok,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_blocked,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack,
  output logic              fwd_pulse,
  output logic              st_valid,
  output logic [NUM_W-1:0]  st_num,
  output logic              st_err,
  output logic              st_hit
);
  dcf_flags_t        flags;
  logic [NSLOT-1:0]  slot_occ;
  logic              slot_rel, slot_clm, qa_hit, qb_hit, locked;
  logic [SW-1:0]     slot_sel;
  logic [ADDR_W-1:0] slot_addr;
  logic              s_we, s_wvalid, s_rvalid;
  logic [IDX_W-1:0]  s_widx, s_ridx;
  logic [ADDR_W-1:0] s_wtag, s_rtag;
  logic [QW-1:0]     s_wqcnt, s_rqcnt;
  logic              lk_q;

  assign flags = '{fwd: cmd_fwd_all, rel: cmd_release, keep: cmd_keep_line,
                   blk: cmd_block, whole: cmd_whole, ext: cmd_ext};

  dcf_slot_table #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_slots (
    .clk, .rst, .rel_en(slot_rel), .clm_en(slot_clm), .sel(slot_sel),
    .clm_addr(slot_addr), .occ_o(slot_occ), .qa_addr(lk_addr), .qa_hit(qa_hit),
    .qb_addr(fill_addr), .qb_hit(qb_hit));

  dcf_line_store #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .QW(QW)) u_lines (
    .clk, .rst, .we(s_we), .w_idx(s_widx), .w_valid(s_wvalid), .w_tag(s_wtag),
    .w_qcnt(s_wqcnt), .r_idx(s_ridx), .r_valid(s_rvalid), .r_tag(s_rtag),
    .r_qcnt(s_rqcnt));

  dcf_seq #(.ADDR_W(ADDR_W), .NUM_W(NUM_W), .NSLOT(NSLOT), .NUM_LINES(NUM_LINES),
            .QW(QW), .COMP_OFS(COMP_OFS)) u_seq (
    .clk, .rst, .cmd_valid, .cmd_ready, .cmd_num, .cmd_stat_req, .cmd_kind,
    .cmd_addr, .cmd_slot, .cmd_flags(flags), .fill_valid, .fill_addr, .fill_cnt,
    .fill_slot_hit(qb_hit), .fill_done, .fill_ok, .slot_occ, .slot_rel, .slot_clm,
    .slot_sel, .slot_addr, .st_we(s_we), .st_widx(s_widx), .st_wvalid(s_wvalid),
    .st_wtag(s_wtag), .st_wqcnt(s_wqcnt), .st_ridx(s_ridx), .st_rvalid(s_rvalid),
    .st_rtag(s_rtag), .st_rqcnt(s_rqcnt), .wb_req, .wb_addr, .wb_ack, .fwd_pulse,
    .st_valid, .st_num, .st_err, .st_hit, .locked);

  always_ff @(posedge clk) begin
    if (rst) lk_q <= 1'b0;
    else     lk_q <= locked | qa_hit;
  end
  assign lk_blocked = lk_q;

  // R11: lookups during a lock always report blocked
  assert_lk_locked_R11: assert property (@(posedge clk) disable iff (rst)
    locked |=> lk_blocked);
endmodule

// File: tb/dcf_flush_ctrl_tb_top.sv
module dcf_flush_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;
  localparam int NL = 8;
  localparam int COMP = 4;
  localparam logic [AW-1:0] B = 40'h12_3400_0000;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_ready, cmd_stat_req = 0;
  logic [15:0] cmd_num = 0;
  logic [1:0] cmd_kind = 0, cmd_slot = 0;
  logic [AW-1:0] cmd_addr = 0, fill_addr = 0, lk_addr = 0, wb_addr;
  logic cmd_fwd_all = 0, cmd_release = 0, cmd_keep_line = 0, cmd_block = 0;
  logic cmd_whole = 0, cmd_ext = 0, fill_valid = 0, fill_done, fill_ok;
  logic [3:0] fill_cnt = 0;
  logic lk_blocked, wb_req, wb_ack = 0, fwd_pulse, st_valid, st_err, st_hit;
  logic [15:0] st_num;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcf_flush_ctrl dut_i (.*);

  int checks = 0, errors = 0;
  // bench model
  logic m_v [NL]; logic [AW-1:0] m_tag [NL]; int m_q [NL];
  logic m_occ [4]; logic [AW-1:0] m_sa [4]; logic m_lock;
  logic [AW-1:0] e_wb [16]; int e_n, e_fwd; logic e_err, e_hit;
  logic [15:0] next_num = 16'h0100;

  task automatic chk(input string tg, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tg, act, exp);
    end
  endtask

  function automatic logic m_blocked(input logic [AW-1:0] a);
    logic r = m_lock;
    for (int i = 0; i < 4; i++) if (m_occ[i] && m_sa[i] == a) r = 1;
    return r;
  endfunction

  task automatic m_line(input logic [AW-1:0] a, input logic first, input logic fw, input logic kp);
    int i = int'(a[2:0]);
    logic h = m_v[i] && m_tag[i] == a;
    if (first) e_hit = h;
    if (h) begin
      if (fw && first) begin e_fwd += m_q[i]; m_q[i] = 0; end
      e_wb[e_n] = a; e_n++;
      if (!kp) m_v[i] = 0;
    end
  endtask

  task automatic m_cmd(input logic [1:0] k, input logic [AW-1:0] a, input logic [1:0] s,
                       input logic fw, rl, kp, bk, wh, ex);
    e_n = 0; e_fwd = 0; e_err = 0; e_hit = 0;
    case (k)
      2'd0: if (wh) begin
        for (int i = 0; i < NL; i++)
          if (m_v[i]) begin e_wb[e_n] = m_tag[i]; e_n++; m_v[i] = 0; end
        m_lock = 1;
      end else if (m_lock || (rl && !m_occ[s]) || (bk && !rl && m_occ[s])) e_err = 1;
      else begin
        if (rl) m_occ[s] = 0;
        m_line(a, 1, fw, kp);
        if (ex) m_line(a + AW'(COMP), 0, fw, kp);
        if (bk) begin m_occ[s] = 1; m_sa[s] = a; end
      end
      2'd1: begin e_err = !m_occ[s]; m_occ[s] = 0; end
      2'd2: m_lock = 0;
      default: e_err = 1;
    endcase
  endtask

  task automatic run_cmd(input string tg, input logic [1:0] k, input logic [AW-1:0] a,
                         input logic [1:0] s, input logic fw, rl, kp, bk, wh, ex, st);
    logic [AW-1:0] a_wb [16]; int a_n = 0, a_fwd = 0, guard = 0;
    logic got = 0, g_err = 0, g_hit = 0; logic [15:0] g_num = 0;
    m_cmd(k, a, s, fw, rl, kp, bk, wh, ex);
    @(negedge clk);
    cmd_kind = k; cmd_addr = a; cmd_slot = s; cmd_fwd_all = fw; cmd_release = rl;
    cmd_keep_line = kp; cmd_block = bk; cmd_whole = wh; cmd_ext = ex;
    cmd_stat_req = st; cmd_num = next_num; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    while (1) begin
      if (wb_ack) wb_ack = 0;
      else if (wb_req) begin if (a_n < 16) a_wb[a_n] = wb_addr; a_n++; wb_ack = 1; end
      if (fwd_pulse) a_fwd++;
      if (st_valid) begin got = 1; g_err = st_err; g_hit = st_hit; g_num = st_num; end
      if (cmd_ready) break;
      @(negedge clk); guard++;
      if (guard > 2000) begin chk({tg, " hang"}, 1, 0); break; end
    end
    chk({tg, " R2 status present"}, got, st);
    if (st) begin
      chk({tg, " R2 status number"}, g_num, next_num);
      chk({tg, " error flag"}, g_err, e_err);
      chk({tg, " R3 hit flag"}, g_hit, e_hit);
    end
    chk({tg, " write-back count"}, a_n, e_n);
    for (int i = 0; i < e_n && i < a_n; i++) chk({tg, " write-back address"}, a_wb[i], e_wb[i]);
    chk({tg, " R5 forward count"}, a_fwd, e_fwd);
    next_num++;
  endtask

  task automatic do_fill(input string tg, input logic [AW-1:0] a, input logic [3:0] c);
    logic ok = !m_blocked(a);
    @(negedge clk); fill_valid = 1; fill_addr = a; fill_cnt = c;
    @(negedge clk); fill_valid = 0;
    chk({tg, " R11 fill_done"}, fill_done, 1);
    chk({tg, " fill_ok"}, fill_ok, ok);
    if (ok) begin m_v[int'(a[2:0])] = 1; m_tag[int'(a[2:0])] = a; m_q[int'(a[2:0])] = c; end
  endtask

  task automatic do_look(input string tg, input logic [AW-1:0] a);
    @(negedge clk); lk_addr = a;
    @(negedge clk);
    chk({tg, " R11 lookup"}, lk_blocked, m_blocked(a));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NL; i++) begin m_v[i] = 0; m_tag[i] = 0; m_q[i] = 0; end
    for (int i = 0; i < 4; i++) begin m_occ[i] = 0; m_sa[i] = 0; end
    m_lock = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 st_valid", st_valid, 0);
    chk("R1 wb_req", wb_req, 0);
    chk("R1 fwd_pulse", fwd_pulse, 0);
    do_look("R1", B);
    // hit with forwarding, then repeat gives a miss
    do_fill("R5", B + 0, 4'd3);
    run_cmd("R5 fwd hit", 0, B + 0, 0, 1, 0, 0, 0, 0, 0, 1);
    run_cmd("R3 miss after invalidate", 0, B + 0, 0, 1, 0, 0, 0, 0, 0, 1);
    do_fill("R3", B + 8, 4'd0);
    run_cmd("R3 tag mismatch", 0, B + 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // keep line
    do_fill("R4", B + 1, 4'd2);
    run_cmd("R4 keep", 0, B + 1, 0, 0, 0, 1, 0, 0, 0, 1);
    run_cmd("R4 keep again", 0, B + 1, 0, 1, 0, 0, 0, 0, 0, 1);
    // companion line
    do_fill("R6", B + 2, 4'd0);
    do_fill("R6", B + 2 + COMP, 4'd0);
    run_cmd("R6 ext", 0, B + 2, 0, 0, 0, 0, 0, 0, 1, 1);
    // no status requested
    do_fill("R2", B + 3, 4'd0);
    run_cmd("R2 quiet", 0, B + 3, 0, 0, 0, 0, 0, 0, 0, 0);
    // release of free slot
    do_fill("R7", B + 3, 4'd0);
    run_cmd("R7 release free", 0, B + 3, 1, 0, 1, 0, 0, 0, 0, 1);
    // claim, block check, release+claim
    run_cmd("R8 claim", 0, B + 3, 1, 0, 0, 0, 1, 0, 0, 1);
    do_look("R8 blocked", B + 3);
    do_fill("R8 refused", B + 3, 4'd0);
    do_fill("R8", B + 5, 4'd0);
    run_cmd("R8 occupied", 0, B + 5, 1, 0, 0, 0, 1, 0, 0, 1);
    run_cmd("R7 release then claim", 0, B + 5, 1, 0, 1, 0, 1, 0, 0, 1);
    do_look("R7 old freed", B + 3);
    do_look("R8 new held", B + 5);
    run_cmd("R10 free slot", 1, B, 1, 0, 0, 0, 0, 0, 0, 1);
    run_cmd("R10 free slot twice", 1, B, 1, 0, 0, 0, 0, 0, 0, 1);
    // whole-cache flush
    run_cmd("R9 claim slot2", 0, B + 7, 2, 0, 0, 0, 1, 0, 0, 1);
    do_fill("R9", B + 1, 4'd1);
    do_fill("R9", B + 4, 4'd0);
    run_cmd("R9 whole", 0, B + 4, 3, 1, 1, 1, 1, 1, 1, 1);
    do_look("R9 locked", B + 11);
    do_fill("R9 locked", B + 2, 4'd0);
    run_cmd("R9 flush while locked", 0, B + 2, 0, 0, 0, 0, 0, 0, 0, 1);
    run_cmd("R9 slot kept", 1, B, 2, 0, 0, 0, 0, 0, 0, 1);
    run_cmd("R10 unlock", 2, B, 0, 0, 0, 0, 0, 0, 0, 1);
    do_look("R10 unlocked", B + 11);
    run_cmd("R10 reserved kind", 3, B, 0, 0, 0, 0, 0, 0, 0, 1);
    // seeded random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(99);
      logic [AW-1:0] a = B + AW'($urandom_range(11));
      if (op < 30) do_fill("R11 rand", a, 4'($urandom_range(15)));
      else if (op < 40) do_look("R8 rand", a);
      else begin
        int kr = $urandom_range(99);
        logic [1:0] k = (kr < 80) ? 2'd0 : (kr < 90) ? 2'd1 : (kr < 98) ? 2'd2 : 2'd3;
        logic [5:0] f = 6'($urandom());
        logic wh = ($urandom_range(19) == 0);
        run_cmd("R3 rand", k, a, 2'($urandom()), f[0], f[1], f[2], f[3], wh, f[5],
                ($urandom_range(3) != 0));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule